// File: doc/BRIEF.md
# Serial Divider Register Loader for a Two-Loop Synthesizer

This block takes a three-wire serial programming stream (serial clock, serial data, load strobe) and turns it into the parallel settings of a synthesizer with two phase-locked loops. Every rising edge of the serial clock pushes one data bit into a 22-bit word register. The most significant bit comes first. A rising edge on the load strobe copies that word into one of four setting banks. Each loop has a reference bank, which holds the reference divide ratio and the phase-detector, charge-pump and output-select flags. Each loop also has a main bank, which holds the swallow count, the main counter, the prescaler modulus select and the power-save flag.

The three serial pins are treated as asynchronous. They are sampled into the block clock domain through a synchronizer chain, and their rising edges are found there. The serial clock must therefore stay high and stay low for at least `SYNC_STAGES + 1` system clocks each. The data and load pins must be held for the same time around the serial-clock edge. The interface is plain control wiring. There is no valid/ready handshake, because the serial master cannot be stalled, and each bank output simply holds its last loaded value.

Top module: `serprog_loader`

## Requirements
- R1: The word register shifts left by one position for each rising edge of `ser_clk`, and the new bit enters at bit 0. After 22 edges, the first bit sent sits in bit 21 (most significant first). Between rising edges the word does not change.
- R2: At a load, word bit 0 picks the bank kind (0 = reference bank, 1 = main bank) and word bit 1 picks the loop (0 = loop 0, 1 = loop 1).
- R3: A reference-bank load takes its fields from the word as follows: the divide ratio from bits 16..2, phase polarity from bit 17, charge-pump boost from bit 18, forced high-Z from bit 19, lock-detect select from bit 20 and monitor select from bit 21.
- R4: A main-bank load takes its fields from the word as follows: the swallow count from bits 8..2, the main counter from bits 19..9, the modulus select from bit 20 and power-save from bit 21.
- R5: Each low-to-high transition of `ser_le` causes exactly one bank update. While `ser_le` stays high, further shifting changes no bank.
- R6: A load changes only the addressed bank. The other three banks keep their contents.
- R7: The asynchronous active-low reset clears every bank field to zero.
- R8: When a serial-clock rising edge and a load-strobe rising edge are detected in the same cycle, the bank receives the word as it was before that shift. The shifted bit is still kept for the next word.
- R9: The power-save flags of either loop have no effect on shifting or loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data bit, most significant first |
| ser_le | input | 1 | Load strobe, rising edge transfers the word |
| ref_ratio_l0 | output | 15 | Loop 0 reference divide ratio |
| pd_pol_l0 | output | 1 | Loop 0 phase-detector polarity |
| cp_boost_l0 | output | 1 | Loop 0 charge-pump high-current select |
| cp_hiz_l0 | output | 1 | Loop 0 charge-pump forced high-Z |
| ld_sel_l0 | output | 1 | Loop 0 lock-detect select |
| mon_sel_l0 | output | 1 | Loop 0 monitor output select |
| swallow_l0 | output | 7 | Loop 0 swallow count |
| main_count_l0 | output | 11 | Loop 0 main counter value |
| mod_sel_l0 | output | 1 | Loop 0 prescaler modulus select |
| pwr_save_l0 | output | 1 | Loop 0 power-save flag |
| ref_ratio_l1 | output | 15 | Loop 1 reference divide ratio |
| pd_pol_l1 | output | 1 | Loop 1 phase-detector polarity |
| cp_boost_l1 | output | 1 | Loop 1 charge-pump high-current select |
| cp_hiz_l1 | output | 1 | Loop 1 charge-pump forced high-Z |
| ld_sel_l1 | output | 1 | Loop 1 lock-detect select |
| mon_sel_l1 | output | 1 | Loop 1 monitor output select |
| swallow_l1 | output | 7 | Loop 1 swallow count |
| main_count_l1 | output | 11 | Loop 1 main counter value |
| mod_sel_l1 | output | 1 | Loop 1 prescaler modulus select |
| pwr_save_l1 | output | 1 | Loop 1 power-save flag |

## Verification
A shift and a load can land in the same clock cycle. This happens when the serial clock and the load strobe rise together, so both pass the synchronizer on the same edge. The bench provokes this by raising both pins on the same drive step after a full word has been shifted. It then judges that the addressed bank took the word from before the extra bit. It also fires a second load and checks that the extra bit did enter the word register, so the next word carries it. The rest of the stimulus mixes random 22-bit words with directed loads at the field limits. It also holds the strobe high across a full shift and applies a mid-run reset. A bench model of the word register and the four banks gives the expected values.

// File: rtl/serprog_pkg.sv
package serprog_pkg;
  parameter int RATIO_W = 15;
  parameter int SWAL_W  = 7;
  parameter int CNT_W   = 11;
  parameter int FLAG_W  = 5;
  parameter int SEL_W   = 2;
  parameter int WORD_W  = SEL_W + RATIO_W + FLAG_W;
  parameter int NLOOP   = 2;

  // Field order follows the word bit positions, highest member = highest bits.
  typedef struct packed {
    logic               mon_sel;
    logic               ld_sel;
    logic               cp_hiz;
    logic               cp_boost;
    logic               pd_pol;
    logic [RATIO_W-1:0] ratio;
  } ref_bank_t;

  typedef struct packed {
    logic              pwr_save;
    logic              mod_sel;
    logic [CNT_W-1:0]  count;
    logic [SWAL_W-1:0] swallow;
  } main_bank_t;
endpackage

// File: rtl/serprog_pins.sv
module serprog_pins #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic ser_le,
  output logic data_s,
  output logic shift_p,
  output logic load_p
);
  localparam int PW = 3;  // bit 0 serial clock, bit 1 data, bit 2 strobe

  logic [STAGES-1:0][PW-1:0] chain;
  logic [1:0]                prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain[g] <= '0;
      end else if (g == 0) begin
        chain[g] <= {ser_le, ser_data, ser_clk};
      end else begin
        chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= {chain[STAGES-1][2], chain[STAGES-1][0]};
  end

  assign data_s  = chain[STAGES-1][1];
  assign shift_p = chain[STAGES-1][0] & ~prev[0];
  assign load_p  = chain[STAGES-1][2] & ~prev[1];

  assert_single_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |=> !load_p);
  assert_single_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_p |=> !shift_p);
endmodule

// File: rtl/serprog_shift.sv
module serprog_shift
  import serprog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_p,
  input  logic              data_s,
  output logic [WORD_W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word <= '0;
    else if (shift_p) word <= {word[WORD_W-2:0], data_s};
  end

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_p |=> $stable(word));
  assert_bit_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_p |=> word[WORD_W-1:1] == $past(word[WORD_W-2:0]));
endmodule

// File: rtl/serprog_banks.sv
module serprog_banks
  import serprog_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load_p,
  input  logic [WORD_W-1:0]      word,
  output ref_bank_t  [NLOOP-1:0] ref_q,
  output main_bank_t [NLOOP-1:0] main_q
);
  logic [NLOOP-1:0] wr_ref;
  logic [NLOOP-1:0] wr_main;

  for (genvar l = 0; l < NLOOP; l++) begin : g_loop
    assign wr_ref[l]  = load_p & ~word[0] & (word[1] == 1'(l));
    assign wr_main[l] = load_p &  word[0] & (word[1] == 1'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ref_q[l] <= '0;
      else if (wr_ref[l]) ref_q[l] <= ref_bank_t'(word[WORD_W-1:SEL_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          main_q[l] <= '0;
      else if (wr_main[l]) main_q[l] <= main_bank_t'(word[WORD_W-1:SEL_W]);
    end

    assert_ref_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ref[l] |=> $stable(ref_q[l]));
    assert_main_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_main[l] |=> $stable(main_q[l]));
  end

  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_main, wr_ref}));
  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_p |-> $countones({wr_main, wr_ref}) == 1);
endmodule

// File: rtl/serprog_loader.sv
module serprog_loader
  import serprog_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk,
  input  logic               ser_data,
  input  logic               ser_le,
  output logic [RATIO_W-1:0] ref_ratio_l0,
  output logic               pd_pol_l0,
  output logic               cp_boost_l0,
  output logic               cp_hiz_l0,
  output logic               ld_sel_l0,
  output logic               mon_sel_l0,
  output logic [SWAL_W-1:0]  swallow_l0,
  output logic [CNT_W-1:0]   main_count_l0,
  output logic               mod_sel_l0,
  output logic               pwr_save_l0,
  output logic [RATIO_W-1:0] ref_ratio_l1,
  output logic               pd_pol_l1,
  output logic               cp_boost_l1,
  output logic               cp_hiz_l1,
  output logic               ld_sel_l1,
  output logic               mon_sel_l1,
  output logic [SWAL_W-1:0]  swallow_l1,
  output logic [CNT_W-1:0]   main_count_l1,
  output logic               mod_sel_l1,
  output logic               pwr_save_l1
);
  logic                   data_s, shift_p, load_p;
  logic [WORD_W-1:0]      word;
  ref_bank_t  [NLOOP-1:0] ref_q;
  main_bank_t [NLOOP-1:0] main_q;

  serprog_pins #(.STAGES(SYNC_STAGES)) u_pins (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .ser_le(ser_le), .data_s(data_s), .shift_p(shift_p), .load_p(load_p));

  serprog_shift u_shift (
    .clk(clk), .rst_n(rst_n), .shift_p(shift_p), .data_s(data_s), .word(word));

  serprog_banks u_banks (
    .clk(clk), .rst_n(rst_n), .load_p(load_p), .word(word),
    .ref_q(ref_q), .main_q(main_q));

  assign ref_ratio_l0  = ref_q[0].ratio;
  assign pd_pol_l0     = ref_q[0].pd_pol;
  assign cp_boost_l0   = ref_q[0].cp_boost;
  assign cp_hiz_l0     = ref_q[0].cp_hiz;
  assign ld_sel_l0     = ref_q[0].ld_sel;
  assign mon_sel_l0    = ref_q[0].mon_sel;
  assign swallow_l0    = main_q[0].swallow;
  assign main_count_l0 = main_q[0].count;
  assign mod_sel_l0    = main_q[0].mod_sel;
  assign pwr_save_l0   = main_q[0].pwr_save;
  assign ref_ratio_l1  = ref_q[1].ratio;
  assign pd_pol_l1     = ref_q[1].pd_pol;
  assign cp_boost_l1   = ref_q[1].cp_boost;
  assign cp_hiz_l1     = ref_q[1].cp_hiz;
  assign ld_sel_l1     = ref_q[1].ld_sel;
  assign mon_sel_l1    = ref_q[1].mon_sel;
  assign swallow_l1    = main_q[1].swallow;
  assign main_count_l1 = main_q[1].count;
  assign mod_sel_l1    = main_q[1].mod_sel;
  assign pwr_save_l1   = main_q[1].pwr_save;

  // Load and shift in one cycle: the bank takes the pre-shift word.
  assert_preshift_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load_p && shift_p && !word[0] && word[1])
      |=> ref_q[1] == ref_bank_t'($past(word[WORD_W-1:SEL_W])));
endmodule

// File: tb/sim_serprog_loader.sv
module sim_serprog_loader;
  localparam int CLK_PERIOD = 10;
  localparam int WW = 22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_data = 1'b0, ser_le = 1'b0;

  logic [14:0] ref_ratio_l0, ref_ratio_l1;
  logic pd_pol_l0, cp_boost_l0, cp_hiz_l0, ld_sel_l0, mon_sel_l0, mod_sel_l0, pwr_save_l0;
  logic pd_pol_l1, cp_boost_l1, cp_hiz_l1, ld_sel_l1, mon_sel_l1, mod_sel_l1, pwr_save_l1;
  logic [6:0]  swallow_l0, swallow_l1;
  logic [10:0] main_count_l0, main_count_l1;

  int checks = 0;
  int errors = 0;

  logic [WW-1:0] m_sr = '0;
  logic [19:0]   exp_ref [2];
  logic [19:0]   exp_main[2];

  always #(CLK_PERIOD/2) clk = ~clk;

  serprog_loader u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
    .ref_ratio_l0(ref_ratio_l0), .pd_pol_l0(pd_pol_l0), .cp_boost_l0(cp_boost_l0),
    .cp_hiz_l0(cp_hiz_l0), .ld_sel_l0(ld_sel_l0), .mon_sel_l0(mon_sel_l0),
    .swallow_l0(swallow_l0), .main_count_l0(main_count_l0), .mod_sel_l0(mod_sel_l0),
    .pwr_save_l0(pwr_save_l0),
    .ref_ratio_l1(ref_ratio_l1), .pd_pol_l1(pd_pol_l1), .cp_boost_l1(cp_boost_l1),
    .cp_hiz_l1(cp_hiz_l1), .ld_sel_l1(ld_sel_l1), .mon_sel_l1(mon_sel_l1),
    .swallow_l1(swallow_l1), .main_count_l1(main_count_l1), .mod_sel_l1(mod_sel_l1),
    .pwr_save_l1(pwr_save_l1));

  // Word builders per R2/R3/R4: bit0 kind, bit1 loop, fields above.
  function automatic logic [WW-1:0] mk_ref(input logic lp, input logic [14:0] ratio,
      input logic pol, input logic boost, input logic hiz, input logic lds, input logic mon);
    return {mon, lds, hiz, boost, pol, ratio, lp, 1'b0};
  endfunction

  function automatic logic [WW-1:0] mk_main(input logic lp, input logic [6:0] sw,
      input logic [10:0] cnt, input logic modsel, input logic ps);
    return {ps, modsel, cnt, sw, lp, 1'b1};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_load(input logic [WW-1:0] w);
    if (w[0]) exp_main[w[1]] = w[21:2];
    else      exp_ref[w[1]]  = w[21:2];
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " ref l0"}, {12'd0, mon_sel_l0, ld_sel_l0, cp_hiz_l0, cp_boost_l0, pd_pol_l0, ref_ratio_l0}, {12'd0, exp_ref[0]});
    chk({tag, " ref l1"}, {12'd0, mon_sel_l1, ld_sel_l1, cp_hiz_l1, cp_boost_l1, pd_pol_l1, ref_ratio_l1}, {12'd0, exp_ref[1]});
    chk({tag, " main l0"}, {12'd0, pwr_save_l0, mod_sel_l0, main_count_l0, swallow_l0}, {12'd0, exp_main[0]});
    chk({tag, " main l1"}, {12'd0, pwr_save_l1, mod_sel_l1, main_count_l1, swallow_l1}, {12'd0, exp_main[1]});
  endtask

  task automatic shift_bit(input logic b);
    ser_data = b;
    tick(3);
    ser_clk = 1'b1;
    m_sr = {m_sr[WW-2:0], b};
    tick(4);
    ser_clk = 1'b0;
    tick(3);
  endtask

  task automatic shift_word(input logic [WW-1:0] w);
    for (int i = WW-1; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic pulse_le();
    ser_le = 1'b1;
    apply_load(m_sr);
    tick(5);
    ser_le = 1'b0;
    tick(5);
  endtask

  task automatic send(input logic [WW-1:0] w);
    shift_word(w);
    pulse_le();
  endtask

  task automatic clear_model();
    for (int l = 0; l < 2; l++) begin
      exp_ref[l] = '0;
      exp_main[l] = '0;
    end
    m_sr = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [WW-1:0] w;
    void'($urandom(32'd4711));
    clear_model();
    tick(4);
    // R7: reset state
    check_all("R7 reset");
    rst_n = 1'b1;
    tick(3);

    // R3: reference layout, low ratio and single flags
    send(mk_ref(1'b0, 15'd3, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1));
    check_all("R3 ref l0");
    send(mk_ref(1'b1, 15'h7fff, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0));
    check_all("R3 ref l1 max");
    // R4: main layout limits
    send(mk_main(1'b1, 7'd127, 11'd2047, 1'b1, 1'b0));
    check_all("R4 main l1 max");
    send(mk_main(1'b0, 7'd0, 11'd3, 1'b0, 1'b1));
    check_all("R4 main l0 min");
    // R2/R6: every code, others stay
    send(mk_ref(1'b0, 15'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    check_all("R2 R6 code 00");
    send(mk_main(1'b1, 7'h55, 11'h2aa, 1'b0, 1'b1));
    check_all("R2 R6 code 11");

    // R5: strobe held high across a full shift
    shift_word(mk_ref(1'b1, 15'h0abc, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1));
    ser_le = 1'b1;
    apply_load(m_sr);
    tick(5);
    shift_word(mk_ref(1'b1, 15'h4321, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    check_all("R5 held strobe");
    ser_le = 1'b0;
    tick(5);
    check_all("R5 after fall");
    pulse_le();
    check_all("R5 second rise");

    // R8: shift edge and load edge together
    shift_word(mk_ref(1'b1, 15'h2468, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    ser_data = 1'b1;
    tick(3);
    ser_clk = 1'b1;
    ser_le = 1'b1;
    apply_load(m_sr);
    m_sr = {m_sr[WW-2:0], 1'b1};
    tick(5);
    ser_clk = 1'b0;
    ser_le = 1'b0;
    tick(5);
    check_all("R8 pre-shift word");
    pulse_le();
    check_all("R8 extra bit kept");

    // R9: both loops in power save, loading continues
    send(mk_main(1'b0, 7'd9, 11'd100, 1'b1, 1'b1));
    send(mk_main(1'b1, 7'd17, 11'd200, 1'b0, 1'b1));
    check_all("R9 ps set");
    send(mk_ref(1'b0, 15'd777, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1));
    send(mk_ref(1'b1, 15'd999, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0));
    check_all("R9 load during ps");

    // R2/R6 random words
    for (int k = 0; k < 40; k++) begin
      w = WW'($urandom);
      send(w);
      check_all("R2 R6 random");
    end

    // R7: reset mid-run
    tick(2);
    rst_n = 1'b0;
    clear_model();
    tick(3);
    check_all("R7 mid reset");
    rst_n = 1'b1;
    tick(3);
    send(mk_main(1'b1, 7'd1, 11'd5, 1'b1, 1'b0));
    check_all("R1 R2 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule